// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the chain of boundary-scan cells that sits between a chip's core logic and its I/O pads. Each pad input has an input cell, each pad output has an output cell, and each group of tristate outputs has a control cell that holds the group's output enable. Every cell has a capture/shift stage, clocked on the rising test clock edge, and an update latch, loaded on the falling edge. The test access port controller supplies the capture, shift and update strobes. The instruction decoder supplies a 3-bit instruction code.

The instruction code selects how pads and core are connected. In system mode signals pass straight through. SAMPLE/PRELOAD takes a snapshot of live signals and preloads the latches without disturbing them. EXTEST and INTEST drive the pads, or the core inputs, from the update latches. CLAMP and CLAMPZ hold the pads at latched values, or float them, without placing the chain in the serial path. A synchronous active-high reset clears the chain; it stands for a test-logic reset.

Chain layout, from the serial output end: input cells 0..N_IN-1 occupy chain bits 0..N_IN-1. Output cells occupy the next N_OUT bits. Control cells occupy the top N_GRP bits. Output pin j belongs to enable group j/(N_OUT/N_GRP).

Top module: `bsr_chain`

## Requirements
- R1: The chain is in the serial path only for codes 1 (SAMPLE/PRELOAD), 2 (EXTEST) and 3 (INTEST), and `scan_sel` reports this. For any other code the strobes leave the shift stage and the latches untouched, and `tdo` is driven low.
- R2: Under codes 1 and 2, a rising edge with `capture_dr` high loads the chain as follows: input cells take `pad_in`, output cells take `core_out`, and control cells take `core_oe`.
- R3: Under code 3, a capture loads each input cell from its own update latch, while output and control cells take `core_out` and `core_oe`.
- R4: With `shift_dr` high, each rising edge moves the chain one bit toward the serial output, and `tdi` enters at the top bit. `tdo` is registered on the falling edge from chain bit 0, so chain bit 0 leaves first. After N shifts, the first `tdi` bit sits in bit 0.
- R5: Update latches load from the shift stage only on a falling edge with `update_dr` high while the chain is selected. Values driven from the latches therefore stay unchanged throughout shifting.
- R6: Under codes 0, 1, 6 and 7, `core_in` equals `pad_in`, `pad_out` equals `core_out`, and `pad_oe` equals `core_oe`.
- R7: Under codes 2, 3 and 4, `pad_out` comes from the output latches and `pad_oe` from the control latches, regardless of `core_out` and `core_oe`.
- R8: Under code 3, `core_in` comes from the input latches, regardless of `pad_in`. Under every other code, `core_in` equals `pad_in`.
- R9: Under code 5 (CLAMPZ), every bit of `pad_oe` is 0, and `pad_out` comes from the output latches.
- R10: Under codes 4 (CLAMP) and 5, a full capture/shift/update sequence leaves the latched pad values unchanged.
- R11: Reset clears the shift stage, all update latches and `tdo` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test-logic reset |
| instr | input | 3 | Current instruction code |
| capture_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge registered |
| scan_sel | output | 1 | Chain is in the serial path |
| pad_in | input | N_IN | Values from input pads |
| core_in | output | N_IN | Values to core inputs |
| core_out | input | N_OUT | Values from core outputs |
| core_oe | input | N_GRP | Core output enables per group |
| pad_out | output | N_OUT | Values to output pads |
| pad_oe | output | N_GRP | Pad output enables per group |

## Verification
The assertions assume that `instr` changes only while all three strobes are low. They also assume that `capture_dr` and `shift_dr` are never high together, as a TAP controller guarantees. The bench meets both assumptions: it changes inputs 1 ns after a rising edge and asserts each strobe in its own cycles. It also holds `instr` fixed across each whole capture/shift/update sequence, so the falling-edge update sees the same selection as the preceding shifts.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    OP_SYSTEM  = 3'd0,
    OP_SAMPLE  = 3'd1,
    OP_EXTEST  = 3'd2,
    OP_INTEST  = 3'd3,
    OP_CLAMP   = 3'd4,
    OP_CLAMPZ  = 3'd5
  } bsr_op_e;

  typedef struct packed {
    logic sel;         // chain in serial path
    logic in_hold;     // input cells capture their own latch
    logic core_force;  // core inputs from latches
    logic pad_force;   // pads from latches
    logic oe_kill;     // all pad enables off
  } bsr_mode_t;

endpackage

// File: rtl/bsr_mode_dec.sv
module bsr_mode_dec
  import bsr_pkg::*;
(
  input  logic [2:0] instr,
  output bsr_mode_t  mode
);

  always_comb begin
    mode = '0;
    unique case (instr)
      OP_SAMPLE: mode.sel = 1'b1;
      OP_EXTEST: begin
        mode.sel       = 1'b1;
        mode.pad_force = 1'b1;
      end
      OP_INTEST: begin
        mode.sel        = 1'b1;
        mode.in_hold    = 1'b1;
        mode.core_force = 1'b1;
        mode.pad_force  = 1'b1;
      end
      OP_CLAMP:  mode.pad_force = 1'b1;
      OP_CLAMPZ: begin
        mode.pad_force = 1'b1;
        mode.oe_kill   = 1'b1;
      end
      default: mode = '0;
    endcase
  end

endmodule

// File: rtl/bsr_shift_stage.sv
module bsr_shift_stage #(
  parameter int LEN = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           cap_en,
  input  logic           shift_en,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_val,
  output logic [LEN-1:0] sh
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
    end else if (sel && cap_en) begin
      sh <= cap_val;
    end else if (sel && shift_en) begin
      sh <= {tdi, sh[LEN-1:1]};
    end
  end

  AST_FROZEN_UNSEL: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(sh)); // R1

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel && shift_en && !cap_en) |=>
      ((sh[LEN-2:0] == $past(sh[LEN-1:1])) && (sh[LEN-1] == $past(tdi)))); // R4

endmodule

// File: rtl/bsr_update_latch.sv
module bsr_update_latch #(
  parameter int LEN = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [LEN-1:0] d,
  output logic [LEN-1:0] q
);

  always_ff @(negedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= d;
    end
  end

  AST_LATCH_HOLD: assert property (@(negedge clk) disable iff (rst)
    !en |=> $stable(q)); // R5

endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_GRP = 2
) (
  input  bsr_mode_t        mode,
  input  logic [N_IN-1:0]  pad_in,
  input  logic [N_IN-1:0]  upd_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] upd_out,
  input  logic [N_GRP-1:0] core_oe,
  input  logic [N_GRP-1:0] upd_ctl,
  output logic [N_IN-1:0]  core_in,
  output logic [N_IN-1:0]  in_cap,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_GRP-1:0] pad_oe
);

  for (genvar i = 0; i < N_IN; i++) begin : g_in_cell
    assign core_in[i] = mode.core_force ? upd_in[i] : pad_in[i];
    assign in_cap[i]  = mode.in_hold    ? upd_in[i] : pad_in[i];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out_cell
    assign pad_out[j] = mode.pad_force ? upd_out[j] : core_out[j];
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_ctl_cell
    assign pad_oe[g] = mode.oe_kill   ? 1'b0 :
                       mode.pad_force ? upd_ctl[g] : core_oe[g];
  end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  parameter int N_GRP = 2
) (
  input  logic             tck,
  input  logic             rst,
  input  logic [2:0]       instr,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic             tdo,
  output logic             scan_sel,
  input  logic [N_IN-1:0]  pad_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_GRP-1:0] pad_oe
);

  localparam int LEN    = N_IN + N_OUT + N_GRP;
  localparam int OUT_LO = N_IN;
  localparam int CTL_LO = N_IN + N_OUT;

  bsr_mode_t        mode;
  logic [LEN-1:0]   sh;
  logic [LEN-1:0]   upd;
  logic [LEN-1:0]   cap_val;
  logic [N_IN-1:0]  in_cap;

  bsr_mode_dec u_dec (
    .instr (instr),
    .mode  (mode)
  );

  assign cap_val  = {core_oe, core_out, in_cap};
  assign scan_sel = mode.sel;

  bsr_shift_stage #(.LEN(LEN)) u_shift (
    .clk      (tck),
    .rst      (rst),
    .sel      (mode.sel),
    .cap_en   (capture_dr),
    .shift_en (shift_dr),
    .tdi      (tdi),
    .cap_val  (cap_val),
    .sh       (sh)
  );

  bsr_update_latch #(.LEN(LEN)) u_latch (
    .clk (tck),
    .rst (rst),
    .en  (mode.sel && update_dr),
    .d   (sh),
    .q   (upd)
  );

  bsr_pin_mux #(.N_IN(N_IN), .N_OUT(N_OUT), .N_GRP(N_GRP)) u_mux (
    .mode     (mode),
    .pad_in   (pad_in),
    .upd_in   (upd[N_IN-1:0]),
    .core_out (core_out),
    .upd_out  (upd[CTL_LO-1:OUT_LO]),
    .core_oe  (core_oe),
    .upd_ctl  (upd[LEN-1:CTL_LO]),
    .core_in  (core_in),
    .in_cap   (in_cap),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo <= 1'b0;
    end else begin
      tdo <= mode.sel ? sh[0] : 1'b0;
    end
  end

  AST_TDO_IDLE: assert property (@(negedge tck) disable iff (rst)
    !mode.sel |=> (tdo == 1'b0)); // R1

  AST_CLAMPZ_FLOAT: assert property (@(posedge tck) disable iff (rst)
    (instr == OP_CLAMPZ) |-> (pad_oe == '0)); // R9

  AST_CLAMP_KEEP: assert property (@(negedge tck) disable iff (rst)
    (instr == OP_CLAMP || instr == OP_CLAMPZ) |=> $stable(pad_out)
      || (instr != OP_CLAMP && instr != OP_CLAMPZ)); // R10

endmodule

// File: tb/bsr_chain_tb.sv
`timescale 1ns/1ps
module bsr_chain_tb_top;

  localparam int NI = 4, NO = 4, NG = 2, L = NI + NO + NG;

  logic          tck = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    instr = 3'd0;
  logic          capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic          tdo, scan_sel;
  logic [NI-1:0] pad_in = '0, core_in;
  logic [NO-1:0] core_out = '0, pad_out;
  logic [NG-1:0] core_oe = '0, pad_oe;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  bsr_chain #(.N_IN(NI), .N_OUT(NO), .N_GRP(NG)) dut_i (
    .tck(tck), .rst(rst), .instr(instr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .scan_sel(scan_sel), .pad_in(pad_in), .core_in(core_in),
    .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // op[22:20] pad_in[19:16] core_out[15:12] core_oe[11:10] scan data[9:0]
  localparam logic [22:0] TBL [8] = '{
    {3'd1, 4'hA, 4'h5, 2'd1, 10'h2C3},
    {3'd2, 4'h3, 4'hC, 2'd2, 10'h15A},
    {3'd4, 4'hF, 4'h0, 2'd0, 10'h3FF},
    {3'd5, 4'h0, 4'hF, 2'd3, 10'h0F0},
    {3'd3, 4'h6, 4'h9, 2'd1, 10'h2A5},
    {3'd3, 4'h9, 4'h3, 2'd2, 10'h11C},
    {3'd0, 4'h5, 4'hA, 2'd3, 10'h3C0},
    {3'd2, 4'hC, 4'h6, 2'd0, 10'h000}
  };

  // model of the latches and shift stage, kept from the requirements
  logic [NI-1:0] m_in  = '0;
  logic [NO-1:0] m_out = '0;
  logic [NG-1:0] m_ctl = '0;
  logic [L-1:0]  m_sh  = '0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic scan(input logic [2:0] op, input logic [3:0] pi, input logic [3:0] co,
                      input logic [1:0] oe, input logic [9:0] d, input bit do_cap,
                      input bit do_upd);
    logic [L-1:0] got, exp_s;
    bit s;
    string tag;
    s = (op == 3'd1 || op == 3'd2 || op == 3'd3);
    @(posedge tck); #1;
    instr = op; pad_in = pi; core_out = co; core_oe = oe; capture_dr = do_cap;
    if (!s)          begin exp_s = '0; tag = "R1 tdo stream"; end
    else if (do_cap) begin
      exp_s = {oe, co, (op == 3'd3) ? m_in : pi};
      tag = (op == 3'd3) ? "R3 intest capture" : "R2 capture";
    end else         begin exp_s = m_sh; tag = "R4 shift-only stream"; end
    if (do_cap) begin @(posedge tck); #1; capture_dr = 1'b0; end
    shift_dr = 1'b1;
    for (int j = 0; j < L; j++) begin
      tdi = d[j];
      @(negedge tck); #0.5;
      got[j] = tdo;
      if (j == L-1 && (op == 3'd2 || op == 3'd3))
        chk("R5 pads held while shifting", 16'(pad_out), 16'(m_out));
      @(posedge tck); #1;
    end
    shift_dr = 1'b0;
    if (s) m_sh = d;
    if (do_upd) begin
      update_dr = 1'b1;
      @(negedge tck); #0.5;
      @(posedge tck); #1;
      update_dr = 1'b0;
      if (s) begin m_in = d[3:0]; m_out = d[7:4]; m_ctl = d[9:8]; end
    end
    chk(tag, 16'(got), 16'(exp_s));
    if (do_upd) begin
      #0.5;
      chk("R1 scan_sel", 16'(scan_sel), 16'(s));
      chk((op == 3'd3) ? "R8 core_in" : "R6 core_in", 16'(core_in),
          16'((op == 3'd3) ? m_in : pi));
      if (op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd5)
        chk((op >= 3'd4) ? "R10 clamp pad_out" : "R7 pad_out", 16'(pad_out), 16'(m_out));
      else
        chk("R6 pad_out", 16'(pad_out), 16'(co));
      if (op == 3'd5)      chk("R9 clampz pad_oe", 16'(pad_oe), 16'(0));
      else if (op == 3'd2 || op == 3'd3 || op == 3'd4)
                           chk("R7 pad_oe", 16'(pad_oe), 16'(m_ctl));
      else                 chk("R6 pad_oe", 16'(pad_oe), 16'(oe));
    end
  endtask

  initial begin
    repeat (3) @(posedge tck);
    #1; rst = 1'b0; instr = 3'd3;
    #1;
    chk("R11 reset tdo", 16'(tdo), 16'(0));
    chk("R11 reset input latches", 16'(core_in), 16'(0));
    instr = 3'd2; #1;
    chk("R11 reset output latches", 16'(pad_out), 16'(0));
    chk("R11 reset control latches", 16'(pad_oe), 16'(0));

    for (int v = 0; v < 8; v++)
      scan(TBL[v][22:20], TBL[v][19:16], TBL[v][15:12], TBL[v][11:10], TBL[v][9:0], 1, 1);

    // R1: unselected shifting leaves the shift stage intact
    scan(3'd2, 4'h0, 4'h0, 2'd0, 10'h1B6, 1, 0);
    scan(3'd4, 4'h0, 4'h0, 2'd0, 10'h3FF, 0, 0);
    scan(3'd2, 4'h0, 4'h0, 2'd0, 10'h000, 0, 1);   // R4 reads back 1B6

    // R11: reset after loading clears latches
    scan(3'd2, 4'h0, 4'h0, 2'd0, 10'h3FF, 1, 1);
    @(posedge tck); #1; rst = 1'b1;
    repeat (2) @(posedge tck);
    #1; rst = 1'b0; m_in = '0; m_out = '0; m_ctl = '0; m_sh = '0;
    #1;
    chk("R11 reset pad_out", 16'(pad_out), 16'(0));
    chk("R11 reset pad_oe", 16'(pad_oe), 16'(0));
    scan(3'd2, 4'h0, 4'h0, 2'd0, 10'h000, 0, 0);   // R11 shift stage zero

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule